// File: doc/BRIEF.md
# Multi-level thermal threshold interrupt

This block watches a stream of temperature codes and compares each new sample against a set of programmable trip points. Each trip point is a per-level trigger value. A single shared offset is added to every trigger value. A level is active only when the temperature code is strictly above its own trigger value plus that offset. The sum is formed one bit wider than the code, so a sum that overflows the code range is a trip point that no code can exceed.

Each level has a raw status bit that follows the comparison on every valid sample, whether or not the level is enabled. When an enabled level goes from inactive to active, its pending bit is set. Software clears a pending bit by writing a one to it. The interrupt output is high while any enabled level has its pending bit set. Level 0 works like every other level. It is meant as the lowest trip point, which can be used to keep cooling actions in step rather than to signal an emergency.

Top module: `thermal_trip_irq`

## Requirements
- R1: After reset, every register reads 0, `lvl_status` is 0 and `irq` is low.
- R2: On a cycle with `sample_vld` high, level n becomes active when `temp_code` > trigger_n + offset, where the sum is unsigned and TEMP_W+1 bits wide. Equality does not activate the level. The result shows on `lvl_status[n]` after the next rising clock edge.
- R3: When trigger_n + offset is greater than 2^TEMP_W - 1, level n never becomes active, even at the highest code.
- R4: On cycles with `sample_vld` low, `lvl_status` and the pending bits keep their values, whatever `temp_code` is.
- R5: `lvl_status[n]` reports the comparison whether or not level n is enabled.
- R6: Pending bit n is set on a valid sample where level n is active, was inactive on the previous valid sample, and is enabled. It is not set again while the level stays active, and it is not set while the level is disabled.
- R7: A write to address 10 clears the pending bits that have a 1 in the written data, and leaves bits written 0 unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R8: `irq` is the OR over all levels of (pending AND enable). Clearing an enable bit masks the interrupt without clearing the pending bit.
- R9: Register map with an 8-bit data path. Addresses 0 to NUM_LVL-1 hold the trigger levels, 8 holds the offset, and 9 holds the enables (bit n = level n). Address 10 holds the pending bits (bit n = level n), and address 11 holds the raw status (read only). Reads are combinational. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld | input | 1 | Qualifies `temp_code` for this cycle |
| temp_code | input | TEMP_W | Current temperature code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | TEMP_W | Register write data |
| reg_rdata | output | TEMP_W | Combinational read data for `reg_addr` |
| lvl_status | output | NUM_LVL | Raw per-level comparison result |
| irq | output | 1 | Level interrupt |

## Verification
The raw status, the pending bits and register writes all come from a single register stage. Their effect is due one clock edge after the cycle that carried the sample or the write. `irq` and the read data are combinational from that state. The bench drives each stimulus for exactly one cycle, steps its model at the same edge, and compares shortly after that edge. Read data is checked a moment after the address changes.

// File: rtl/thermal_trip_irq.sv
module thermal_trip_irq #(
  parameter int TEMP_W  = 8,
  parameter int NUM_LVL = 5,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_vld,
  input  logic [TEMP_W-1:0]  temp_code,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [TEMP_W-1:0]  reg_wdata,
  output logic [TEMP_W-1:0]  reg_rdata,
  output logic [NUM_LVL-1:0] lvl_status,
  output logic               irq
);
  localparam int SUM_W = TEMP_W + 1;
  localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(11);

  logic [TEMP_W-1:0]  trig_q [NUM_LVL];
  logic [SUM_W-1:0]   trip   [NUM_LVL];
  logic [TEMP_W-1:0]  off_q;
  logic [NUM_LVL-1:0] en_q, pend_q, raw_q, hit, rise, clr;

  assign clr  = (reg_we && reg_addr == A_PEND) ? reg_wdata[NUM_LVL-1:0] : '0;
  assign rise = sample_vld ? (hit & ~raw_q & en_q) : '0;

  for (genvar n = 0; n < NUM_LVL; n++) begin : g_lvl
    assign trip[n] = {1'b0, trig_q[n]} + {1'b0, off_q};
    assign hit[n]  = {1'b0, temp_code} > trip[n];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) trig_q[n] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(n)) trig_q[n] <= reg_wdata;

    AST_RISE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[n]) |-> $past(sample_vld && en_q[n])) else $error("pend without sample"); // R6
    AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[n]) |-> !$past(raw_q[n])) else $error("pend without edge"); // R6
    AST_NO_OVERFLOW_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_vld && trip[n] > SUM_W'((1 << TEMP_W) - 1)) |=> !raw_q[n]) else $error("overflow trip"); // R3
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[n] && clr[n]) |=> pend_q[n]) else $error("clear beat set"); // R7
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      off_q  <= '0;
      en_q   <= '0;
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_OFF) off_q <= reg_wdata;
      if (reg_we && reg_addr == A_EN)  en_q  <= reg_wdata[NUM_LVL-1:0];
      if (sample_vld) raw_q <= hit;
      pend_q <= (pend_q & ~clr) | rise;
    end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_LVL; n++)
      if (reg_addr == ADDR_W'(n)) reg_rdata = trig_q[n];
    case (reg_addr)
      A_OFF:   reg_rdata = off_q;
      A_EN:    reg_rdata = TEMP_W'(en_q);
      A_PEND:  reg_rdata = TEMP_W'(pend_q);
      A_STAT:  reg_rdata = TEMP_W'(raw_q);
      default: ;
    endcase
  end

  assign lvl_status = raw_q;
  assign irq        = |(pend_q & en_q);

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(raw_q)) else $error("status moved"); // R4
  AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q != '0)) else $error("irq without pending"); // R8
endmodule

// File: tb/tb_thermal_trip_irq.sv
module tb_thermal_trip_irq;
  localparam int TW = 8, NL = 5, AW = 4;
  logic clk = 0, rst_n = 0, sample_vld = 0, reg_we = 0;
  logic [TW-1:0] temp_code = '0, reg_wdata = '0, reg_rdata;
  logic [AW-1:0] reg_addr = '0;
  logic [NL-1:0] lvl_status;
  logic irq;

  thermal_trip_irq #(.TEMP_W(TW), .NUM_LVL(NL), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .temp_code(temp_code),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lvl_status(lvl_status), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [TW-1:0] trig_m [NL];
  logic [TW-1:0] off_m = '0;
  logic [NL-1:0] en_m = '0, raw_m = '0, pend_m = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] calc_hit(logic [TW-1:0] t);
    logic [NL-1:0] h;
    for (int n = 0; n < NL; n++) h[n] = {1'b0, t} > ({1'b0, trig_m[n]} + {1'b0, off_m});
    return h;
  endfunction

  task automatic step(logic we, logic [AW-1:0] a, logic [TW-1:0] d, logic v, logic [TW-1:0] t);
    logic [NL-1:0] h, clrv, nraw, npend;
    reg_we = we; reg_addr = a; reg_wdata = d; sample_vld = v; temp_code = t;
    h = calc_hit(t);
    clrv = (we && a == 4'd10) ? d[NL-1:0] : '0;
    nraw = v ? h : raw_m;
    npend = (pend_m & ~clrv) | (v ? (h & ~raw_m & en_m) : '0);
    @(posedge clk); #2;
    raw_m = nraw; pend_m = npend;
    if (we) begin
      if (a < NL) trig_m[a] = d;
      if (a == 4'd8) off_m = d;
      if (a == 4'd9) en_m = d[NL-1:0];
    end
    reg_we = 0; sample_vld = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [TW-1:0] d); step(1, a, d, 0, 8'd0); endtask
  task automatic smp(logic [TW-1:0] t); step(0, 4'd0, 8'd0, 1, t); endtask

  task automatic check_outs(string req);
    chk(req, 32'(lvl_status), 32'(raw_m));
    chk(req, 32'(irq), 32'(|(pend_m & en_m)));
    reg_addr = 4'd10; #1;
    chk(req, 32'(reg_rdata), 32'(pend_m));
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [TW-1:0] exp);
    reg_addr = a; #1; chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int n = 0; n < NL; n++) trig_m[n] = '0;
    #35 rst_n = 1; #2;
    check_outs("R1");
    for (int a = 0; a < 12; a++) rd("R1 readback", 4'(a), 8'd0);

    wr(0, 10); wr(1, 40); wr(2, 80); wr(3, 120); wr(4, 200); wr(8, 5); wr(9, 8'h1F);
    rd("R9 trig2", 4'd2, 8'd80); rd("R9 offset", 4'd8, 8'd5); rd("R9 enable", 4'd9, 8'h1F);
    rd("R9 unmapped", 4'd6, 8'd0);

    smp(15); check_outs("R2 equal not active");
    chk("R2 equal", 32'(lvl_status), 32'h0);
    smp(16); check_outs("R2 R6 level0 rise");
    chk("R6 pend0", 32'(pend_m), 32'h1);
    rd("R9 status", 4'd11, 8'h01);
    wr(10, 8'h01); check_outs("R7 w1c");
    smp(16); check_outs("R6 no re-set while high");
    chk("R6 held", 32'(pend_m), 32'h0);
    step(0, 0, 0, 0, 8'd255); check_outs("R4 no sample");
    chk("R4 status hold", 32'(lvl_status), 32'h1);

    wr(4, 253); smp(255); check_outs("R3 overflow");
    chk("R3 lvl4 inactive", 32'(lvl_status[4]), 32'h0);

    wr(10, 8'h1F); smp(0); check_outs("R2 all low");
    wr(9, 8'h1D); smp(100); check_outs("R5 disabled level status");
    chk("R5 raw1", 32'(lvl_status[1]), 32'h1);
    chk("R6 disabled no pend", 32'(pend_m[1]), 32'h0);

    wr(10, 8'h00); check_outs("R7 write zero");
    smp(0); wr(10, 8'h1F);
    step(1, 4'd10, 8'h01, 1, 8'd100); check_outs("R7 set beats clear");
    chk("R7 pend0 kept", 32'(pend_m[0]), 32'h1);
    wr(9, 8'h00); check_outs("R8 masked");
    chk("R8 irq low", 32'(irq), 32'h0);
    rd("R8 pending kept", 4'd10, 8'(pend_m));
    wr(9, 8'h1F); check_outs("R8 unmasked");

    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) smp(8'($urandom_range(0, 255)));
      else if (op == 5) wr(4'($urandom_range(0, NL - 1)), 8'($urandom_range(0, 255)));
      else if (op == 6) wr(4'd8, 8'($urandom_range(0, 60)));
      else if (op == 7) wr(4'd9, 8'($urandom_range(0, 31)));
      else if (op == 8) wr(4'd10, 8'($urandom_range(0, 31)));
      else step(1, 4'd10, 8'($urandom_range(0, 31)), 1, 8'($urandom_range(0, 255)));
      check_outs("R2 R6 R7 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule